// File: doc/BRIEF.md
# DMA Descriptor Decoder and Executor

This block accepts 128-bit DMA descriptors, each presented as two 64-bit quadwords on a valid/ready fetch interface. It reads a four-bit type code from the top of the second quadword and converts the descriptor into one request on a simple memory request port. A memory-copy descriptor becomes a request carrying a source address, a destination address and a byte length. A status-write descriptor becomes a request that stores one 64-bit data word at a destination address.

Each request is held until the downstream side accepts it. One cycle after that acceptance the block pulses a completion output. A status-write descriptor may also ask for an interrupt. In that case an interrupt pulse appears together with the completion pulse. Descriptors with any other type code are consumed and dropped, and an error pulse marks each one.

Copy lengths are carried in units of an alignment granule. The byte length is the length field shifted left by a parameterised alignment shift, which is 6 by default, so one granule is 64 bytes.

Top module: `dma_desc_exec`

## Requirements
- R1: After reset, desc_ready is 1, and req_valid, done_pulse, irq_pulse and bad_type_pulse are all 0.
- R2: The type code is desc_qw1[63:60]. Code 1 (copy) loads a request with req_is_status=0, req_src=desc_qw0[45:0] and req_dst=desc_qw1[45:0]. req_valid goes high the cycle after the descriptor is taken.
- R3: For a copy, req_len equals desc_qw0[63:46] shifted left by ALIGN_SHIFT. With the default of 6, req_len is 24 bits wide.
- R4: Code 2 (status write) loads a request with req_is_status=1, req_data=desc_qw0, req_dst=desc_qw1[45:0] and req_len=0.
- R5: While req_valid is 1 and req_ready is 0, the request fields stay unchanged, req_valid stays 1, and no new descriptor is taken.
- R6: done_pulse is 1 for exactly the one cycle after each cycle in which req_valid and req_ready are both 1.
- R7: irq_pulse is 1 together with done_pulse only when the accepted request came from a status descriptor whose desc_qw1[59] was 1.
- R8: A descriptor with any type code other than 1 or 2 is taken and dropped. bad_type_pulse is 1 in the following cycle. No request and no done_pulse result from it.
- R9: desc_ready equals (not req_valid) or req_ready. A new descriptor can therefore load in the same cycle the previous request is accepted.
- R10: In a copy descriptor, desc_qw1[59] has no effect: a copy never raises irq_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_qw0 | input | 64 | First quadword |
| desc_qw1 | input | 64 | Second quadword (type, interrupt flag, destination) |
| req_valid | output | 1 | Memory request pending |
| req_ready | input | 1 | Downstream accepts the request |
| req_is_status | output | 1 | 0 = copy, 1 = status write |
| req_src | output | 46 | Copy source address |
| req_dst | output | 46 | Destination address |
| req_len | output | 24 | Copy length in bytes |
| req_data | output | 64 | Status-write data word |
| done_pulse | output | 1 | One descriptor completed |
| irq_pulse | output | 1 | Interrupt requested by a completed status write |
| bad_type_pulse | output | 1 | Unknown descriptor dropped |

## Verification
The hardest situation to reach is the overlap where one request is accepted in the same cycle as the next descriptor is taken. In that cycle the completion for the old request and the load of the new one happen together. A directed sequence holds req_ready high while a second descriptor waits, then checks the first completion alongside the second request's fields. Long random stalls on req_ready test the hold behaviour. Random type codes, including unused ones, test the drop path and interrupt flags set on copies.

// File: rtl/dma_desc_exec.sv
module dma_desc_exec #(
  parameter int ADDR_W      = 46,
  parameter int ALIGN_SHIFT = 6,
  parameter int LEN_LSB     = 46,
  parameter int IRQ_BIT     = 59
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_valid,
  output logic                desc_ready,
  input  logic [63:0]         desc_qw0,
  input  logic [63:0]         desc_qw1,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                req_is_status,
  output logic [ADDR_W-1:0]   req_src,
  output logic [ADDR_W-1:0]   req_dst,
  output logic [64-LEN_LSB+ALIGN_SHIFT-1:0] req_len,
  output logic [63:0]         req_data,
  output logic                done_pulse,
  output logic                irq_pulse,
  output logic                bad_type_pulse
);
  localparam int LEN_W = 64 - LEN_LSB + ALIGN_SHIFT;

  logic [3:0] kind_code;
  logic       take, hand, is_copy, is_stat, want_irq;

  assign kind_code  = desc_qw1[63:60];
  assign is_copy    = (kind_code == 4'd1);
  assign is_stat    = (kind_code == 4'd2);
  assign desc_ready = !req_valid || req_ready;
  assign take       = desc_valid && desc_ready;
  assign hand       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid      <= 1'b0;
      req_is_status  <= 1'b0;
      req_src        <= '0;
      req_dst        <= '0;
      req_len        <= '0;
      req_data       <= '0;
      want_irq       <= 1'b0;
      done_pulse     <= 1'b0;
      irq_pulse      <= 1'b0;
      bad_type_pulse <= 1'b0;
    end else begin
      done_pulse     <= hand;
      irq_pulse      <= hand && req_is_status && want_irq;
      bad_type_pulse <= take && !is_copy && !is_stat;
      if (take && (is_copy || is_stat)) begin
        req_valid     <= 1'b1;
        req_is_status <= is_stat;
        req_src       <= is_copy ? desc_qw0[ADDR_W-1:0] : '0;
        req_dst       <= desc_qw1[ADDR_W-1:0];
        req_len       <= is_copy ? LEN_W'({desc_qw0[63:LEN_LSB], {ALIGN_SHIFT{1'b0}}}) : '0;
        req_data      <= is_stat ? desc_qw0 : '0;
        want_irq      <= is_stat && desc_qw1[IRQ_BIT];
      end else if (hand) begin
        req_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_dst) && $stable(req_len)
      && $stable(req_data) && $stable(req_is_status)); // R5
  AST_DONE_AFTER_HAND: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(req_valid && req_ready)); // R6
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> done_pulse); // R7
  AST_BAD_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_type_pulse |-> $past(desc_valid && desc_ready)); // R8
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> !desc_ready); // R9
endmodule

// File: tb/dma_desc_exec_bench.sv
module dma_desc_exec_bench;
  localparam int SH = 6;
  logic clk = 0, rst_n = 0;
  logic desc_valid = 0, req_ready = 0;
  logic [63:0] qw0 = '0, qw1 = '0;
  logic desc_ready, req_valid, req_is_status, done_pulse, irq_pulse, bad_type_pulse;
  logic [45:0] req_src, req_dst;
  logic [23:0] req_len;
  logic [63:0] req_data;
  int total = 0, bad = 0, cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  dma_desc_exec u_dma_desc_exec (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_qw0(qw0), .desc_qw1(qw1), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_status(req_is_status), .req_src(req_src), .req_dst(req_dst),
    .req_len(req_len), .req_data(req_data), .done_pulse(done_pulse),
    .irq_pulse(irq_pulse), .bad_type_pulse(bad_type_pulse));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_len(logic [63:0] a);
    return {a[63:46], {SH{1'b0}}};
  endfunction

  function automatic logic [63:0] mk_q1(logic [3:0] t, logic ib, logic [45:0] d);
    return {t, ib, 13'($urandom), d};
  endfunction

  task automatic check_loaded(logic [63:0] a, logic [63:0] b);
    logic st = (b[63:60] == 4'd2);
    chk("R2 req_valid", req_valid, 1);
    chk("R2 kind", req_is_status, st);
    chk("R2 dst", req_dst, b[45:0]);
    if (st) begin
      chk("R4 data", req_data, a);
      chk("R4 len", req_len, 0);
    end else begin
      chk("R2 src", req_src, a[45:0]);
      chk("R3 len", req_len, exp_len(a));
    end
  endtask

  task automatic run_one(logic [63:0] a, logic [63:0] b, int stall);
    logic [3:0] t = b[63:60];
    logic eirq = (t == 4'd2) && b[59];
    @(negedge clk);
    desc_valid = 1; qw0 = a; qw1 = b; req_ready = 0;
    @(negedge clk);
    desc_valid = 0;
    if (t != 4'd1 && t != 4'd2) begin
      chk("R8 bad pulse", bad_type_pulse, 1);
      chk("R8 no req", req_valid, 0);
      @(negedge clk);
      chk("R8 bad one cycle", bad_type_pulse, 0);
      chk("R8 no done", done_pulse, 0);
      return;
    end
    chk("R8 no bad", bad_type_pulse, 0);
    check_loaded(a, b);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R5 held valid", req_valid, 1);
      chk("R5 held dst", req_dst, b[45:0]);
      chk("R9 not ready", desc_ready, 0);
      chk("R6 no early done", done_pulse, 0);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk("R6 done", done_pulse, 1);
    chk(t == 4'd1 ? "R10 copy irq" : "R7 irq", irq_pulse, eirq);
    chk("R6 released", req_valid, 0);
    @(negedge clk);
    chk("R6 done one cycle", done_pulse, 0);
    chk("R7 irq one cycle", irq_pulse, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 desc_ready", desc_ready, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 done", done_pulse, 0);
    chk("R1 irq", irq_pulse, 0);
    chk("R1 bad", bad_type_pulse, 0);

    run_one({18'h3FFFF, 46'h1234}, mk_q1(4'd1, 1'b1, 46'h3FFF_FFFF_FFFF), 0); // R3 max, R10
    run_one(64'hDEAD_BEEF_CAFE_F00D, mk_q1(4'd2, 1'b1, 46'h40), 3);           // R7
    run_one(64'h5, mk_q1(4'd2, 1'b0, 46'h80), 1);                             // R7 no irq
    run_one(64'h0, mk_q1(4'd0, 1'b0, 46'h0), 0);                              // R8
    run_one(64'h0, mk_q1(4'd15, 1'b1, 46'h0), 0);                             // R8

    // R9 overlap: accept A while taking B
    a = {18'h00012, 46'h777}; b = mk_q1(4'd1, 1'b0, 46'h999);
    @(negedge clk); desc_valid = 1; qw0 = a; qw1 = b;
    @(negedge clk); desc_valid = 0;
    check_loaded(a, b);
    a = 64'h0123_4567_89AB_CDEF; b = mk_q1(4'd2, 1'b1, 46'h1000);
    req_ready = 1; desc_valid = 1; qw0 = a; qw1 = b;
    #1 chk("R9 ready during accept", desc_ready, 1);
    @(negedge clk); desc_valid = 0; req_ready = 0;
    chk("R9 done for first", done_pulse, 1);
    chk("R10 first no irq", irq_pulse, 0);
    check_loaded(a, b);
    req_ready = 1;
    @(negedge clk); req_ready = 0;
    chk("R9 done for second", done_pulse, 1);
    chk("R7 second irq", irq_pulse, 1);

    for (int n = 0; n < 300; n++) begin
      logic [3:0] t;
      int r = $urandom_range(0, 9);
      t = (r < 4) ? 4'd1 : (r < 8) ? 4'd2 : 4'($urandom);
      a = {$urandom, $urandom};
      b = mk_q1(t, 1'($urandom), {14'($urandom), $urandom});
      run_one(a, b, $urandom_range(0, 4));
    end

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule